// File: doc/BRIEF.md
# Exclusive Reservation Monitor for Load-Reserved / Store-Conditional

This block sits between a single hart's memory stage and an AHB5-style data port that carries an exclusive-access flag. Each memory operation arrives as a request carrying an operation code and an address. The possible operations are a plain load, a plain store, a load-reserved, a store-conditional, or one bus access of an atomic memory operation.

The block drives the address phase of the bus and raises the exclusive flag for the operations that need it. It follows each data phase through the ready and exclusive-okay responses. It also keeps one local reservation covering one naturally aligned 32-bit word. A store-conditional that has no matching reservation is answered locally and never reaches the bus. Any other store-conditional goes out as an exclusive write, and the global monitor decides whether it succeeds.

The bus cannot overlap exclusive transfers. When an exclusive request arrives while an exclusive data phase is still open, the block holds it for one cycle. That bubble also gives a load-reserved response time to update the reservation before the next store-conditional address phase is decided.

The request port is valid/ready. A request is taken on a cycle where both `req_valid` and `req_ready` are high. `req_ready` depends on the offered operation, so the source must hold the operation and address stable until it is accepted. `req_ready` is low while a data phase is waiting (`bus_hready` low). It is also low for an exclusive request while an exclusive data phase is open.

Top module: `excl_monitor`

## Requirements
- R1: An accepted request that goes to the bus drives `bus_aph_valid` in its acceptance cycle, with `bus_haddr` equal to `req_addr`. `bus_hwrite` is set for a store (op 1), a store-conditional (op 3) and the write access of an atomic (op 5), and is clear for a load (op 0), a load-reserved (op 2) and the read access of an atomic (op 4).
- R2: `bus_hexcl` is high with an address phase exactly when the op is 2, 3, 4 or 5. It is low for ops 0 and 1.
- R3: While an issued data phase is waiting with `bus_hready` low, `req_ready` is low. With no open data phase, `req_ready` is high.
- R4: An exclusive request offered while an exclusive data phase is open is not accepted that cycle: `excl_stall` is high and `req_ready` is low. With zero wait states, it is accepted one cycle later. A non-exclusive request behind an exclusive op is not stalled.
- R5: When a load-reserved data phase completes, the reservation is set to the word `addr[AW-1:2]` if `bus_hexokay` is high, and cleared otherwise.
- R6: A store-conditional with no reservation, or with a reservation for a different word, issues no address phase. In the next cycle `sc_rsp_valid` is high with `sc_rsp_result` equal to 1.
- R7: A store-conditional with a matching reservation issues an exclusive write. In the cycle its data phase completes, `sc_rsp_valid` is high and `sc_rsp_result` is 0 if `bus_hexokay` is high, and 1 otherwise.
- R8: Every accepted store-conditional clears the reservation, whether it succeeds or fails.
- R9: `trap_clear` clears the reservation. This takes priority over a load-reserved completing in the same cycle.
- R10: Reset clears the reservation and leaves the bus and the response outputs idle.
- R11: Plain loads, plain stores and atomic accesses leave the reservation unchanged and produce no store-conditional response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | Operation: 0 load, 1 store, 2 load-reserved, 3 store-conditional, 4 atomic read access, 5 atomic write access |
| req_addr | input | AW | Byte address |
| trap_clear | input | 1 | Trap entry; drops the reservation |
| bus_aph_valid | output | 1 | Address phase active |
| bus_haddr | output | AW | Address-phase address |
| bus_hwrite | output | 1 | Address-phase write direction |
| bus_hexcl | output | 1 | Address-phase exclusive flag |
| bus_hready | input | 1 | Data phase completes this cycle |
| bus_hexokay | input | 1 | Global monitor granted exclusivity |
| excl_stall | output | 1 | Exclusive request held back by a bubble |
| sc_rsp_valid | output | 1 | Store-conditional result available |
| sc_rsp_result | output | XLEN | Store-conditional result: 0 success, 1 failure |

## Verification
A stale or wrong reservation is not visible directly at the ports. It shows up at the next store-conditional. If the block thinks a reservation exists when it does not, an exclusive write appears on the bus in the acceptance cycle. If it wrongly thinks there is none, `bus_aph_valid` stays low and a failure response follows one cycle later. A broken data-phase tracker shows up within the same cycle as a missing bubble or a wrong `req_ready` during wait states. It can also show up one cycle later as a store-conditional response in the wrong cycle or with the wrong value.

// File: rtl/exmon_pkg.sv
package exmon_pkg;

  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_LR     = 3'd2,
    OP_SC     = 3'd3,
    OP_AMO_RD = 3'd4,
    OP_AMO_WR = 3'd5
  } exop_e;

  function automatic logic op_is_excl(exop_e op);
    return (op == OP_LR) || (op == OP_SC) || (op == OP_AMO_RD) || (op == OP_AMO_WR);
  endfunction

  function automatic logic op_is_write(exop_e op);
    return (op == OP_STORE) || (op == OP_SC) || (op == OP_AMO_WR);
  endfunction

endpackage

// File: rtl/exmon_dphase.sv
module exmon_dphase
  import exmon_pkg::*;
#(
  parameter int AW = 32,
  localparam int WW = AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          aph_fire,
  input  exop_e         aph_op,
  input  logic [WW-1:0] aph_word,
  input  logic          hready,
  output logic          dph_valid,
  output exop_e         dph_op,
  output logic [WW-1:0] dph_word,
  output logic          dph_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dph_valid <= 1'b0;
      dph_op    <= OP_LOAD;
      dph_word  <= '0;
    end else if (aph_fire) begin
      dph_valid <= 1'b1;
      dph_op    <= aph_op;
      dph_word  <= aph_word;
    end else if (hready) begin
      dph_valid <= 1'b0;
    end
  end

  assign dph_done = dph_valid & hready;

endmodule

// File: rtl/exmon_resv.sv
module exmon_resv #(
  parameter int AW = 32,
  localparam int WW = AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lr_done,
  input  logic          lr_ok,
  input  logic [WW-1:0] lr_word,
  input  logic          sc_taken,
  input  logic          trap_clear,
  input  logic [WW-1:0] query_word,
  output logic          match
);

  logic          held_q;
  logic [WW-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      word_q <= '0;
    end else if (trap_clear || sc_taken) begin
      held_q <= 1'b0;
    end else if (lr_done) begin
      held_q <= lr_ok;
      word_q <= lr_word;
    end
  end

  assign match = held_q && (word_q == query_word);

endmodule

// File: rtl/exmon_issue.sv
module exmon_issue
  import exmon_pkg::*;
(
  input  logic  req_valid,
  input  exop_e op,
  input  logic  dph_valid,
  input  exop_e dph_op,
  input  logic  hready,
  input  logic  resv_match,
  output logic  req_ready,
  output logic  stall,
  output logic  fire,
  output logic  aph_fire,
  output logic  sc_local_fail
);

  logic waiting;
  logic excl_clash;

  always_comb begin
    waiting       = dph_valid && !hready;
    excl_clash    = op_is_excl(op) && dph_valid && op_is_excl(dph_op);
    req_ready     = !waiting && !excl_clash;
    stall         = req_valid && excl_clash;
    fire          = req_valid && req_ready;
    sc_local_fail = (op == OP_SC) && !resv_match;
    aph_fire      = fire && !sc_local_fail;
  end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import exmon_pkg::*;
#(
  parameter int AW   = 32,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic            trap_clear,
  output logic            bus_aph_valid,
  output logic [AW-1:0]   bus_haddr,
  output logic            bus_hwrite,
  output logic            bus_hexcl,
  input  logic            bus_hready,
  input  logic            bus_hexokay,
  output logic            excl_stall,
  output logic            sc_rsp_valid,
  output logic [XLEN-1:0] sc_rsp_result
);

  localparam int WW = AW - 2;

  exop_e         op;
  exop_e         dph_op;
  logic          dph_valid;
  logic          dph_done;
  logic [WW-1:0] dph_word;
  logic [WW-1:0] req_word;
  logic          resv_match;
  logic          fire;
  logic          aph_fire;
  logic          sc_local_fail;
  logic          local_rsp_q;
  logic          bus_sc_rsp;

  assign op       = exop_e'(req_op);
  assign req_word = req_addr[AW-1:2];

  exmon_issue u_issue (
    .req_valid    (req_valid),
    .op           (op),
    .dph_valid    (dph_valid),
    .dph_op       (dph_op),
    .hready       (bus_hready),
    .resv_match   (resv_match),
    .req_ready    (req_ready),
    .stall        (excl_stall),
    .fire         (fire),
    .aph_fire     (aph_fire),
    .sc_local_fail(sc_local_fail)
  );

  exmon_dphase #(.AW(AW)) u_dph (
    .clk      (clk),
    .rst_n    (rst_n),
    .aph_fire (aph_fire),
    .aph_op   (op),
    .aph_word (req_word),
    .hready   (bus_hready),
    .dph_valid(dph_valid),
    .dph_op   (dph_op),
    .dph_word (dph_word),
    .dph_done (dph_done)
  );

  exmon_resv #(.AW(AW)) u_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .lr_done   (dph_done && (dph_op == OP_LR)),
    .lr_ok     (bus_hexokay),
    .lr_word   (dph_word),
    .sc_taken  (fire && (op == OP_SC)),
    .trap_clear(trap_clear),
    .query_word(req_word),
    .match     (resv_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) local_rsp_q <= 1'b0;
    else        local_rsp_q <= fire && sc_local_fail;
  end

  assign bus_sc_rsp    = dph_done && (dph_op == OP_SC);
  assign sc_rsp_valid  = local_rsp_q || bus_sc_rsp;
  assign sc_rsp_result = {{(XLEN-1){1'b0}}, local_rsp_q || (bus_sc_rsp && !bus_hexokay)};

  assign bus_aph_valid = aph_fire;
  assign bus_haddr     = req_addr;
  assign bus_hwrite    = aph_fire && op_is_write(op);
  assign bus_hexcl     = aph_fire && op_is_excl(op);

endmodule

// File: rtl/exmon_chk.sv
module exmon_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [2:0]      req_op,
  input logic            trap_clear,
  input logic            bus_aph_valid,
  input logic            bus_hexcl,
  input logic            excl_stall,
  input logic            sc_rsp_valid,
  input logic [XLEN-1:0] sc_rsp_result
);

  p_aph_needs_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_aph_valid |-> (req_valid && req_ready));

  p_excl_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_aph_valid |-> (bus_hexcl == (req_op inside {3'd2, 3'd3, 3'd4, 3'd5})));

  p_no_back_to_back_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_aph_valid && bus_hexcl) |=> !(bus_aph_valid && bus_hexcl));

  p_stall_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    excl_stall |-> !req_ready);

  p_local_fail_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 3'd3 && !bus_aph_valid) |=> (sc_rsp_valid && sc_rsp_result[0]));

  p_result_one_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sc_rsp_valid |-> (sc_rsp_result[XLEN-1:1] == '0));

  p_trap_drops_resv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trap_clear) && req_valid && req_ready && req_op == 3'd3) |-> !bus_aph_valid);

endmodule

bind excl_monitor exmon_chk #(.XLEN(XLEN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_op       (req_op),
  .trap_clear   (trap_clear),
  .bus_aph_valid(bus_aph_valid),
  .bus_hexcl    (bus_hexcl),
  .excl_stall   (excl_stall),
  .sc_rsp_valid (sc_rsp_valid),
  .sc_rsp_result(sc_rsp_result)
);

// File: tb/excl_monitor_tb.sv
`timescale 1ns/1ps
module excl_monitor_tb;
  localparam int AW = 32;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [2:0]      req_op = 3'd0;
  logic [AW-1:0]   req_addr = '0;
  logic            trap_clear = 1'b0;
  logic            bus_aph_valid;
  logic [AW-1:0]   bus_haddr;
  logic            bus_hwrite;
  logic            bus_hexcl;
  logic            bus_hready = 1'b1;
  logic            bus_hexokay = 1'b0;
  logic            excl_stall;
  logic            sc_rsp_valid;
  logic [XLEN-1:0] sc_rsp_result;

  int n_chk = 0;
  int n_bad = 0;
  logic          m_held = 1'b0;
  logic [AW-3:0] m_word = '0;

  always #5 clk = ~clk;

  excl_monitor #(.AW(AW), .XLEN(XLEN)) u_dut (.*);

  function automatic logic exp_excl(logic [2:0] op);
    return op >= 3'd2 && op <= 3'd5;
  endfunction
  function automatic logic exp_write(logic [2:0] op);
    return op == 3'd1 || op == 3'd3 || op == 3'd5;
  endfunction

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [AW-1:0] addr,
                       input logic exok, input int waits, input logic trap_dph);
    logic issued;
    issued = !(op == 3'd3 && !(m_held && m_word == addr[AW-1:2]));
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr;
    #2;
    check(req_ready == 1'b1, "R3 ready when idle", req_ready, 1);
    check(excl_stall == 1'b0, "R4 no stall when idle", excl_stall, 0);
    check(bus_aph_valid == issued, (op == 3'd3) ? "R6 sc issue decision" : "R1 address phase", bus_aph_valid, issued);
    if (issued) begin
      check(bus_haddr == addr, "R1 haddr", bus_haddr, addr);
      check(bus_hwrite == exp_write(op), "R1 hwrite", bus_hwrite, exp_write(op));
      check(bus_hexcl == exp_excl(op), "R2 hexcl", bus_hexcl, exp_excl(op));
    end
    if (op == 3'd3) m_held = 1'b0; // R8
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (issued) begin
      for (int w = 0; w < waits; w++) begin
        bus_hready = 1'b0;
        #2;
        check(req_ready == 1'b0, "R3 ready low in wait", req_ready, 0);
        check(sc_rsp_valid == 1'b0, "R7 no early response", sc_rsp_valid, 0);
        @(negedge clk);
      end
      bus_hready = 1'b1; bus_hexokay = exok; trap_clear = trap_dph;
      #2;
      if (op == 3'd3) begin
        check(sc_rsp_valid == 1'b1, "R7 bus sc response valid", sc_rsp_valid, 1);
        check(sc_rsp_result == {31'd0, !exok}, "R7 bus sc result", sc_rsp_result, !exok);
      end else begin
        check(sc_rsp_valid == 1'b0, "R11 no response for non-sc", sc_rsp_valid, 0);
      end
    end else begin
      trap_clear = trap_dph;
      #2;
      check(sc_rsp_valid == 1'b1, "R6 local response valid", sc_rsp_valid, 1);
      check(sc_rsp_result == 1, "R6 local result", sc_rsp_result, 1);
    end
    if (op == 3'd2) begin m_held = exok; m_word = addr[AW-1:2]; end // R5
    if (trap_dph) m_held = 1'b0; // R9
    @(posedge clk);
    @(negedge clk);
    trap_clear = 1'b0; bus_hexokay = 1'b0;
  endtask

  // Load-reserved followed immediately by op2 on the same address.
  task automatic b2b(input logic [2:0] op2, input logic [AW-1:0] addr);
    logic stall_exp;
    stall_exp = exp_excl(op2);
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd2; req_addr = addr;
    #2;
    check(req_ready == 1'b1, "R4 first op accepted", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    req_op = op2; bus_hready = 1'b1; bus_hexokay = 1'b1;
    #2;
    check(excl_stall == stall_exp, "R4 stall flag", excl_stall, stall_exp);
    check(req_ready == !stall_exp, "R4 ready behind lr", req_ready, !stall_exp);
    check(bus_aph_valid == !stall_exp, "R4 address phase behind lr", bus_aph_valid, !stall_exp);
    m_held = 1'b1; m_word = addr[AW-1:2];
    if (stall_exp) begin
      @(posedge clk);
      @(negedge clk);
      bus_hexokay = 1'b0;
      #2;
      check(req_ready == 1'b1, "R4 accepted after bubble", req_ready, 1);
      check(bus_aph_valid && bus_hexcl, "R5 sc sees fresh reservation", bus_aph_valid, 1);
    end
    if (op2 == 3'd3) m_held = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; bus_hexokay = 1'b1;
    #2;
    if (op2 == 3'd3) begin
      check(sc_rsp_valid && sc_rsp_result == 0, "R7 sc success after bubble", sc_rsp_result, 0);
    end
    @(posedge clk);
    @(negedge clk);
    bus_hexokay = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20211204));
    repeat (3) @(negedge clk);
    #2;
    check(bus_aph_valid == 0, "R10 bus idle in reset", bus_aph_valid, 0);
    check(sc_rsp_valid == 0, "R10 no response in reset", sc_rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(req_ready == 1 && excl_stall == 0, "R10 idle after reset", req_ready, 1);
    // R10: reservation starts empty
    do_op(3'd3, 32'h1000, 1'b1, 0, 1'b0);
    // R5/R7: reserve, succeed; R8: second sc fails locally
    do_op(3'd2, 32'h1004, 1'b1, 0, 1'b0);
    do_op(3'd3, 32'h1006, 1'b1, 1, 1'b0);
    do_op(3'd3, 32'h1004, 1'b1, 0, 1'b0);
    // R5: refused reservation
    do_op(3'd2, 32'h1008, 1'b0, 0, 1'b0);
    do_op(3'd3, 32'h1008, 1'b1, 0, 1'b0);
    // R6: word mismatch
    do_op(3'd2, 32'h1008, 1'b1, 0, 1'b0);
    do_op(3'd3, 32'h100C, 1'b1, 0, 1'b0);
    // R7: global monitor refuses the write
    do_op(3'd2, 32'h1010, 1'b1, 2, 1'b0);
    do_op(3'd3, 32'h1010, 1'b0, 0, 1'b0);
    // R9: trap in the lr data phase wins
    do_op(3'd2, 32'h1014, 1'b1, 0, 1'b1);
    do_op(3'd3, 32'h1014, 1'b1, 0, 1'b0);
    // R11: other ops keep the reservation
    do_op(3'd2, 32'h1018, 1'b1, 0, 1'b0);
    do_op(3'd0, 32'h1018, 1'b0, 1, 1'b0);
    do_op(3'd1, 32'h1018, 1'b0, 0, 1'b0);
    do_op(3'd4, 32'h1018, 1'b1, 0, 1'b0);
    do_op(3'd5, 32'h1018, 1'b1, 0, 1'b0);
    do_op(3'd3, 32'h1018, 1'b1, 0, 1'b0);
    // R4: back-to-back pairs
    b2b(3'd3, 32'h1020);
    b2b(3'd0, 32'h1024);
    b2b(3'd4, 32'h1028);
    do_op(3'd3, 32'h1028, 1'b1, 0, 1'b0);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      logic [AW-1:0] a;
      op = 3'($urandom % 6);
      if (($urandom % 3) == 0) op = 3'd3;
      a  = 32'h2000 + 32'(($urandom % 4) * 4) + 32'($urandom % 4);
      do_op(op, a, ($urandom % 4) != 0, int'($urandom % 3), ($urandom % 10) == 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule